// File: doc/BRIEF.md
# Supply-Qualified Access Sequencer

This block decides when a memory array may be accessed, based on the state of two supply rails: a core rail and an I/O rail. Each rail reports two comparator results as digital levels. One says the rail is above its minimum operating level. The other says it is above its write-lockout threshold. The block passes all four levels through a synchroniser and then moves through three phases in a fixed order: locked, warm-up and open.

The warm-up phase starts once every status bit is high. It lasts a fixed number of clock cycles, set by a parameter (for example, 2 ms divided by the clock period). Read and write requests are granted only in the open phase. If either lockout bit goes low, write grants stop in the same cycle the synchronised level arrives. On the next edge the block returns to the locked phase, so a full warm-up is needed again.

Any write request that is refused sets a sticky flag. The flag stays set until reset.

Top module: `pwr_write_inhibit_seq`

## Requirements
- R1: After reset, `phase` is 0 (locked), both grants are low and `writeDropped` is low.
- R2: Phase codes are 0 locked, 1 warm-up and 2 open. The locked phase is left only when all four status inputs are high. No other combination of the four inputs leaves phase 0.
- R3: Status inputs pass through a SYNC_STAGES-flop synchroniser. When all four inputs go high before clock edge 1, `phase` becomes 1 after edge SYNC_STAGES+1. It becomes 2 after edge SYNC_STAGES+1+STARTUP_CYCLES, and not earlier.
- R4: No read or write is granted while `phase` is 0 or 1.
- R5: While `phase` is 2, the following grants are combinational in the same cycle. `grantRead` equals `reqValid & ~reqWrite`. `grantWrite` equals `reqValid & reqWrite` as long as both synchronised lockout bits are high.
- R6: When a lockout input falls while `phase` is 2, `grantWrite` drops in the cycle the synchronised level goes low. `phase` becomes 0 on the following edge.
- R7: During warm-up, losing any of the four status bits returns `phase` to 0. The warm-up count is discarded.
- R8: While `phase` is 2, losing only the minimum-level bits leaves the phase at 2 and writes still granted. The lockout bits alone end the open phase.
- R9: A write request that is not granted sets `writeDropped` on the next edge. The flag holds until reset. Refused reads never set it.
- R10: After any return to phase 0, reaching phase 2 again takes the full delay of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| coreMinOk | input | 1 | Core rail above minimum level (asynchronous) |
| coreInhOk | input | 1 | Core rail above write-lockout threshold (asynchronous) |
| ioMinOk | input | 1 | I/O rail above minimum level (asynchronous) |
| ioInhOk | input | 1 | I/O rail above write-lockout threshold (asynchronous) |
| reqValid | input | 1 | Access request present |
| reqWrite | input | 1 | Request is a write (1) or a read (0) |
| grantRead | output | 1 | Read allowed this cycle |
| grantWrite | output | 1 | Write allowed this cycle |
| phase | output | 2 | 0 locked, 1 warm-up, 2 open |
| writeDropped | output | 1 | Sticky: a write was refused |

## Verification
Every one of the sixteen combinations of the four status bits is applied while the block is locked. Only the all-high pattern may leave phase 0, which shows that each bit is required on its own. The warm-up is followed cycle by cycle, so an off-by-one in the synchroniser or the counter shows up as a phase change at the wrong edge.

Each status bit is dropped in turn at a different point of the warm-up, which separates a true restart from a paused count. In the open phase, the minimum-level bits are dropped without the lockout bits, and then a lockout bit is dropped with a write pending. Together these show that only a lockout bit ends the open phase and that the write gate closes one edge before the phase does.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    PH_LOCKED = 2'd0,
    PH_WARMUP = 2'd1,
    PH_OPEN   = 2'd2
  } phase_e;

  typedef struct packed {
    logic accessOpen;
    logic writeOpen;
  } gate_s;
endpackage

// File: rtl/pwr_status_sync.sv
module pwr_status_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= rawIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int STARTUP_CYCLES = 200000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   minOk,
  input  logic   inhOk,
  output phase_e phase,
  output gate_s  gate
);
  localparam int CNT_W = $clog2(STARTUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STARTUP_CYCLES - 1);

  phase_e phaseNext;
  logic [CNT_W-1:0] warmCnt, warmCntNext;

  always_comb begin
    phaseNext   = phase;
    warmCntNext = '0;
    unique case (phase)
      PH_LOCKED: if (minOk && inhOk) phaseNext = PH_WARMUP;
      PH_WARMUP: begin
        if (!(minOk && inhOk))  phaseNext = PH_LOCKED;
        else if (warmCnt == LAST) phaseNext = PH_OPEN;
        else                    warmCntNext = warmCnt + 1'b1;
      end
      PH_OPEN:   if (!inhOk) phaseNext = PH_LOCKED;
      default:   phaseNext = PH_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_LOCKED;
      warmCnt <= '0;
    end else begin
      phase   <= phaseNext;
      warmCnt <= warmCntNext;
    end
  end

  always_comb begin
    gate.accessOpen = (phase == PH_OPEN);
    gate.writeOpen  = (phase == PH_OPEN) && inhOk;
  end
endmodule

// File: rtl/pwr_access_gate.sv
module pwr_access_gate
  import pwrseq_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  gate_s gate,
  input  logic  reqValid,
  input  logic  reqWrite,
  output logic  grantRead,
  output logic  grantWrite,
  output logic  writeDropped
);
  logic refusedWrite;

  assign grantRead    = reqValid && !reqWrite && gate.accessOpen;
  assign grantWrite   = reqValid && reqWrite && gate.writeOpen;
  assign refusedWrite = reqValid && reqWrite && !gate.writeOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             writeDropped <= 1'b0;
    else if (refusedWrite) writeDropped <= 1'b1;
  end
endmodule

// File: rtl/pwr_write_inhibit_seq.sv
module pwr_write_inhibit_seq
  import pwrseq_pkg::*;
#(
  parameter int STARTUP_CYCLES = 200000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       coreMinOk,
  input  logic       coreInhOk,
  input  logic       ioMinOk,
  input  logic       ioInhOk,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       grantRead,
  output logic       grantWrite,
  output logic [1:0] phase,
  output logic       writeDropped
);
  logic [3:0] statusSync;
  logic       minOk, inhOk;
  phase_e     phaseQ;
  gate_s      gate;

  pwr_status_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  ({ioInhOk, ioMinOk, coreInhOk, coreMinOk}),
    .syncOut(statusSync)
  );

  assign minOk = statusSync[0] && statusSync[2];
  assign inhOk = statusSync[1] && statusSync[3];

  pwr_seq_ctrl #(.STARTUP_CYCLES(STARTUP_CYCLES)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .minOk(minOk),
    .inhOk(inhOk),
    .phase(phaseQ),
    .gate (gate)
  );

  pwr_access_gate uGate (
    .clk         (clk),
    .rstN        (rstN),
    .gate        (gate),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .grantRead   (grantRead),
    .grantWrite  (grantWrite),
    .writeDropped(writeDropped)
  );

  assign phase = phaseQ;
endmodule

// File: rtl/pwr_write_inhibit_seq_chk.sv
module pwr_write_inhibit_seq_chk #(
  parameter int STARTUP_CYCLES = 200000
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqWrite,
  input logic       grantRead,
  input logic       grantWrite,
  input logic [1:0] phase,
  input logic       writeDropped
);
  int warmSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warmSeen <= 0;
    else if (phase == 2'd1) warmSeen <= warmSeen + 1;
    else                    warmSeen <= 0;
  end

  a_r2_phase_code: assert property (@(posedge clk) disable iff (!rstN)
    phase != 2'd3);

  a_r2_open_after_warmup: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd2) |-> ($past(phase) != 2'd0));

  a_r3_warmup_length: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd2 && $past(phase) == 2'd1) |-> (warmSeen == STARTUP_CYCLES));

  a_r4_no_grant_closed: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 2'd2) |-> (!grantRead && !grantWrite));

  a_r5_grant_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    (grantRead || grantWrite) |-> (reqValid && (grantWrite == reqWrite)));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    writeDropped |=> writeDropped);
endmodule

bind pwr_write_inhibit_seq pwr_write_inhibit_seq_chk #(.STARTUP_CYCLES(STARTUP_CYCLES)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqWrite    (reqWrite),
  .grantRead   (grantRead),
  .grantWrite  (grantWrite),
  .phase       (phase),
  .writeDropped(writeDropped)
);

// File: tb/pwr_write_inhibit_seq_test.sv
module pwr_write_inhibit_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 12;
  localparam int SYNC       = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] status = 4'b0000;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic grantRead, grantWrite, writeDropped;
  logic [1:0] phase;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_write_inhibit_seq #(.STARTUP_CYCLES(N), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rstN(rstN),
    .coreMinOk(status[0]), .coreInhOk(status[1]),
    .ioMinOk(status[2]), .ioInhOk(status[3]),
    .reqValid(reqValid), .reqWrite(reqWrite),
    .grantRead(grantRead), .grantWrite(grantWrite),
    .phase(phase), .writeDropped(writeDropped)
  );

  task automatic check(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; status = 4'b0000; reqValid = 1'b0; reqWrite = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Caller has just set all status bits high at a negedge.
  task automatic runWarmup(input string req);
    for (int k = 1; k <= SYNC + 1 + N + 2; k++) begin
      int expPh;
      @(negedge clk);
      expPh = (k < SYNC + 1) ? 0 : (k < SYNC + 1 + N) ? 1 : 2;
      check(phase, expPh, req, $sformatf("phase after edge %0d", k));
      check(grantRead, (reqValid && !reqWrite && expPh == 2) ? 1 : 0, "R4",
            $sformatf("read grant after edge %0d", k));
    end
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    doReset();
    // R1: reset state
    #1;
    check(phase, 0, "R1", "phase at reset");
    check(grantRead, 0, "R1", "grantRead at reset");
    check(grantWrite, 0, "R1", "grantWrite at reset");
    check(writeDropped, 0, "R1", "flag at reset");

    // R2: every incomplete status pattern keeps the block locked
    for (int c = 0; c < 15; c++) begin
      @(negedge clk); status = 4'(c);
      repeat (SYNC + 2) @(negedge clk);
      check(phase, 0, "R2", $sformatf("pattern %0d stays locked", c));
    end

    // R4 / R9: requests while locked
    @(negedge clk); reqValid = 1'b1; reqWrite = 1'b0; #1;
    check(grantRead, 0, "R4", "read while locked");
    @(negedge clk);
    check(writeDropped, 0, "R9", "refused read leaves flag");
    reqWrite = 1'b1; #1;
    check(grantWrite, 0, "R4", "write while locked");
    @(negedge clk); reqValid = 1'b0; reqWrite = 1'b0;
    check(writeDropped, 1, "R9", "refused write sets flag");
    repeat (3) @(negedge clk);
    check(writeDropped, 1, "R9", "flag held");

    // R3: warm-up timing from reset, read requested throughout
    doReset();
    reqValid = 1'b1; reqWrite = 1'b0; status = 4'b1111;
    runWarmup("R3");
    reqValid = 1'b0;

    // R5: request combinations in the open phase
    for (int r = 0; r < 4; r++) begin
      @(negedge clk); reqValid = r[1]; reqWrite = r[0]; #1;
      check(grantRead, (r == 2) ? 1 : 0, "R5", $sformatf("read grant req %0d", r));
      check(grantWrite, (r == 3) ? 1 : 0, "R5", $sformatf("write grant req %0d", r));
    end
    @(negedge clk); reqValid = 1'b0; reqWrite = 1'b0;
    check(writeDropped, 0, "R9", "granted writes leave flag");

    // R8: minimum-level loss alone keeps open
    status = 4'b1010;
    repeat (SYNC + 2) @(negedge clk);
    check(phase, 2, "R8", "open after min loss");
    reqValid = 1'b1; reqWrite = 1'b1; #1;
    check(grantWrite, 1, "R8", "write after min loss");
    @(negedge clk); status = 4'b1111;
    repeat (SYNC + 1) @(negedge clk);
    check(grantWrite, 1, "R6", "write granted before lockout");

    // R6: lockout bit falls with a write pending
    status = 4'b0111;
    @(negedge clk);
    check(grantWrite, 1, "R6", "write after 1 edge");
    @(negedge clk);
    check(grantWrite, 0, "R6", "write blocked after sync");
    check(phase, 2, "R6", "phase still open");
    @(negedge clk);
    check(phase, 0, "R6", "locked next edge");
    check(writeDropped, 1, "R9", "blocked write sets flag");
    reqValid = 1'b0; reqWrite = 1'b0;

    // R10: full warm-up again
    @(negedge clk); status = 4'b1111;
    runWarmup("R10");

    // R7: drop each bit during warm-up, then a full warm-up is needed
    for (int b = 0; b < 4; b++) begin
      @(negedge clk); status = 4'b0000;
      repeat (SYNC + 2) @(negedge clk);
      status = 4'b1111;
      repeat (SYNC + 2 + b) @(negedge clk);
      check(phase, 1, "R7", $sformatf("warm-up before drop of bit %0d", b));
      status[b] = 1'b0;
      repeat (SYNC + 1) @(negedge clk);
      check(phase, 0, "R7", $sformatf("locked after drop of bit %0d", b));
      status = 4'b1111;
      runWarmup("R7");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    finished = 1'b1;
    $finish;
  end
endmodule